// File: doc/BRIEF.md
# Supply Rail Sequencing Controller

This block is a synchronous controller that powers a processor module's supplies in a fixed order and removes them in the reverse order. It drives four enables: the high-voltage DC input rail, the 5 V plane, the 3.3 V plane, and the core regulator. It decides when to move on from digital good flags that external comparators produce. Each threshold has its own flag: DC input at or above 4.7 V, 5 V plane at or above 4.5 V, 3.3 V plane at or above 3.0 V. It also reads the core regulator's power-good output and the status of the switched 3.3 V rail, which is off in the sleep and soft-off states.

A request input starts power-up while it is high and starts power-down when it falls. The controller gives the regulator a bounded time, TIMEOUT_CYC clock cycles (one second at the default clock), to report power-good. If power-good does not arrive in that time, the controller drops the regulator enable and latches a fault. The combined power-OK output is high only while the controller is running, the regulator reports power-good, and the switched 3.3 V rail is good. Every input passes through a two-flop synchroniser before use.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset all four enables, `pwr_ok_o` and `fault_o` are low.
- R2: With the request high, the DC input enable rises first. The 5 V and 3.3 V enables rise together, and only after the DC input good flag has been high.
- R3: The regulator enable rises only when the DC, 5 V and 3.3 V good flags are all high.
- R4: If the regulator power-good never reaches the controller, the regulator enable stays high for exactly TIMEOUT_CYC cycles. It then drops and `fault_o` rises.
- R5: Power-good counts as seen in time if it goes high at the input no later than cycle TIMEOUT_CYC-3 after the regulator enable rises. Cycle 0 is the first cycle the enable is high, and two cycles go to synchronisation. Power-good seen in time puts the controller in the running state with no fault.
- R6: While running, `pwr_ok_o` equals regulator power-good AND the switched 3.3 V good flag, three cycles after an input change. When the switched rail goes low (sleep or soft-off), `pwr_ok_o` goes low while the regulator stays enabled.
- R7: `pwr_ok_o` is never high unless the regulator enable is high and regulator power-good has been observed high.
- R8: Power-down drops the regulator enable first. The 5 V and 3.3 V enables drop only after power-good is low. The DC input enable drops last, only after both plane good flags are low.
- R9: If any of the three rail good flags drops while the regulator is enabled, the controller starts the orderly power-down of R8.
- R10: The fault state holds `fault_o` high with the regulator off until the request goes low. The controller then clears `fault_o` and powers down in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req_i | input | 1 | Power request: high to bring rails up, low to bring them down |
| good_dc_i | input | 1 | DC input rail at or above 4.7 V |
| good_5v_i | input | 1 | 5 V plane at or above 4.5 V |
| good_3v3_i | input | 1 | 3.3 V plane at or above 3.0 V |
| good_3v3sw_i | input | 1 | Switched 3.3 V rail present (low in sleep and soft-off) |
| vr_pgood_i | input | 1 | Core regulator power-good |
| en_dc_o | output | 1 | DC input rail enable |
| en_5v_o | output | 1 | 5 V plane enable |
| en_3v3_o | output | 1 | 3.3 V plane enable |
| en_vr_o | output | 1 | Core regulator enable |
| pwr_ok_o | output | 1 | Combined power-OK |
| fault_o | output | 1 | Latched power-good timeout fault |

## Verification
The bench sweeps the delay of regulator power-good across every cycle from 0 to just past the timeout. The boundary at TIMEOUT_CYC-3 catches a counter that is off by one, or a synchroniser latency that is ignored: such a design would fault on a regulator that reported in time, or would accept one that reported late. On every power-down the bench logs when each enable falls, and checks the flags at that moment. A design that removed the planes while power-good was still high, or removed the DC input before the planes had collapsed, shows up there. Separate runs drop a plane's good flag while the system is running and take the switched rail away. These runs catch a controller that keeps the regulator on after a rail loss, or that holds power-OK high through sleep.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [3:0] {
        S_OFF,
        S_DC_UP,
        S_PL_UP,
        S_VR_WAIT,
        S_RUN,
        S_DN_VR,
        S_DN_PL,
        S_DN_DC,
        S_FAULT
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       dc_en;
        logic       pl_en;
        logic       vr_en;
        logic       pwr_ok;
        logic       fault;
    } seq_regs_t;

    // bit positions inside the synchronised input bundle
    localparam int IN_REQ  = 0;
    localparam int IN_DC   = 1;
    localparam int IN_5V   = 2;
    localparam int IN_3V3  = 3;
    localparam int IN_SW   = 4;
    localparam int IN_PG   = 5;
    localparam int IN_W    = 6;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i)           cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == LAST);

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (cnt_q == '0)); // R4
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int CLK_HZ      = 25_000_000,
    parameter int TIMEOUT_CYC = CLK_HZ,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req_i,
    input  logic good_dc_i,
    input  logic good_5v_i,
    input  logic good_3v3_i,
    input  logic good_3v3sw_i,
    input  logic vr_pgood_i,
    output logic en_dc_o,
    output logic en_5v_o,
    output logic en_3v3_o,
    output logic en_vr_o,
    output logic pwr_ok_o,
    output logic fault_o
);
    logic [IN_W-1:0] raw_in, syn;
    logic req_s, dc_s, v5_s, v33_s, sw_s, pg_s, rails_ok;
    logic tmo_run, tmo_exp;
    seq_regs_t d, q;

    assign raw_in = {vr_pgood_i, good_3v3sw_i, good_3v3_i, good_5v_i, good_dc_i, pwr_req_i};

    pwr_seq_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn)
    );

    assign req_s    = syn[IN_REQ];
    assign dc_s     = syn[IN_DC];
    assign v5_s     = syn[IN_5V];
    assign v33_s    = syn[IN_3V3];
    assign sw_s     = syn[IN_SW];
    assign pg_s     = syn[IN_PG];
    assign rails_ok = dc_s && v5_s && v33_s;

    assign tmo_run = (q.st == S_VR_WAIT);

    pwr_seq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run_i(tmo_run), .expired_o(tmo_exp)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_OFF:     if (req_s) d.st = S_DC_UP;
            S_DC_UP:   if (!req_s) d.st = S_DN_VR;
                       else if (dc_s) d.st = S_PL_UP;
            S_PL_UP:   if (!req_s || !dc_s) d.st = S_DN_VR;
                       else if (v5_s && v33_s) d.st = S_VR_WAIT;
            S_VR_WAIT: if (!req_s || !rails_ok) d.st = S_DN_VR;
                       else if (pg_s) d.st = S_RUN;
                       else if (tmo_exp) d.st = S_FAULT;
            S_RUN:     if (!req_s || !rails_ok) d.st = S_DN_VR;
            S_DN_VR:   if (!pg_s) d.st = S_DN_PL;
            S_DN_PL:   if (!v5_s && !v33_s) d.st = S_DN_DC;
            S_DN_DC:   if (!dc_s) d.st = S_OFF;
            S_FAULT:   if (!req_s) d.st = S_DN_VR;
            default:   d.st = S_OFF;
        endcase

        case (d.st)
            S_OFF:     begin d.dc_en = 1'b0; d.pl_en = 1'b0; d.vr_en = 1'b0; end
            S_DC_UP:   begin d.dc_en = 1'b1; end
            S_PL_UP:   begin d.dc_en = 1'b1; d.pl_en = 1'b1; end
            S_VR_WAIT,
            S_RUN:     begin d.dc_en = 1'b1; d.pl_en = 1'b1; d.vr_en = 1'b1; end
            S_DN_VR,
            S_FAULT:   begin d.vr_en = 1'b0; end
            S_DN_PL:   begin d.vr_en = 1'b0; d.pl_en = 1'b0; end
            default:   begin d.dc_en = 1'b0; d.pl_en = 1'b0; d.vr_en = 1'b0; end
        endcase
        d.fault  = (d.st == S_FAULT);
        d.pwr_ok = (d.st == S_RUN) && pg_s && sw_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_OFF, default: 1'b0};
        else        q <= d;
    end

    assign en_dc_o  = q.dc_en;
    assign en_5v_o  = q.pl_en;
    assign en_3v3_o = q.pl_en;
    assign en_vr_o  = q.vr_en;
    assign pwr_ok_o = q.pwr_ok;
    assign fault_o  = q.fault;

    AST_PL_AFTER_DC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pl_en) |-> $past(dc_s) && q.dc_en); // R2
    AST_VR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.vr_en) |-> $past(rails_ok)); // R3
    AST_TMO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_run && tmo_exp && !pg_s && req_s && rails_ok) |=> (q.fault && !q.vr_en)); // R4
    AST_OK_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pwr_ok) |-> $past(pg_s)); // R7
    AST_OK_WITH_VR: assert property (@(posedge clk) disable iff (!rst_n)
        q.pwr_ok |-> q.vr_en); // R7
    AST_DN_PL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.pl_en) |-> !q.vr_en && $past(!pg_s)); // R8
    AST_DN_DC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.dc_en) |-> !q.pl_en && $past(!v5_s && !v33_s)); // R8
    AST_FAULT_VR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        q.fault |-> !q.vr_en); // R10
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 12;
    localparam int WDOG_CYC   = 150_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_req = 1'b0;
    logic good_dc = 1'b0, good_5v = 1'b0, good_3v3 = 1'b0, good_sw = 1'b1, vr_pgood = 1'b0;
    logic en_dc, en_5v, en_3v3, en_vr, pwr_ok, fault;

    logic drop_dc = 1'b0, drop_5v = 1'b0, drop_3v3 = 1'b0;
    int   pg_delay = 0;
    int   en_cnt = 0;
    int   n_checks = 0, n_errors = 0;
    int   tcyc = 0;
    int   t_vr = 0, t_pl = 0, t_dc = 0;
    int   vr_len = 0, last_vr_len = 0;
    logic p_vr = 1'b0, p_pl = 1'b0, p_dc = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_ctrl #(.TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_req_i(pwr_req),
        .good_dc_i(good_dc), .good_5v_i(good_5v), .good_3v3_i(good_3v3),
        .good_3v3sw_i(good_sw), .vr_pgood_i(vr_pgood),
        .en_dc_o(en_dc), .en_5v_o(en_5v), .en_3v3_o(en_3v3), .en_vr_o(en_vr),
        .pwr_ok_o(pwr_ok), .fault_o(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0d)", req, act, exp, tcyc);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // rail and regulator model plus sequence monitor
    always @(negedge clk) begin
        tcyc++;
        if (rst_n) begin
            if (en_5v && !p_pl) chk(good_dc == 1'b1, "R2 planes rise after DC good", int'(good_dc), 1);
            if (en_vr && !p_vr) chk(good_dc && good_5v && good_3v3, "R3 regulator gated on rails",
                                    int'({good_dc, good_5v, good_3v3}), 7);
            if (pwr_ok) chk(vr_pgood && en_vr, "R7 power-ok needs power-good", int'({vr_pgood, en_vr}), 3);
            if (!en_vr && p_vr) begin t_vr = tcyc; last_vr_len = vr_len; end
            if (!en_5v && p_pl) begin
                t_pl = tcyc;
                chk(vr_pgood == 1'b0, "R8 planes off after power-good low", int'(vr_pgood), 0);
            end
            if (!en_dc && p_dc) begin
                t_dc = tcyc;
                chk(!good_5v && !good_3v3, "R8 DC off after planes low", int'({good_5v, good_3v3}), 0);
            end
        end
        vr_len = en_vr ? vr_len + 1 : 0;
        p_vr = en_vr; p_pl = en_5v; p_dc = en_dc;

        good_dc  <= en_dc  && !drop_dc;
        good_5v  <= en_5v  && !drop_5v;
        good_3v3 <= en_3v3 && !drop_3v3;
        if (en_vr) begin
            vr_pgood <= (en_cnt >= pg_delay);
            en_cnt = en_cnt + 1;
        end else begin
            vr_pgood <= 1'b0;
            en_cnt = 0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (!done && tcyc > WDOG_CYC) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", tcyc, WDOG_CYC);
            summary();
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_vr_rise();
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (en_vr) break;
        end
    endtask

    task automatic power_down_and_check(input string tag);
        pwr_req = 1'b0;
        wait_cyc(30);
        chk({en_dc, en_5v, en_3v3, en_vr} == 4'b0, {tag, " all enables off"},
            int'({en_dc, en_5v, en_3v3, en_vr}), 0);
        chk(fault == 1'b0, {tag, " fault cleared"}, int'(fault), 0);
        chk(t_vr < t_pl && t_pl < t_dc, {tag, " reverse order"}, t_dc - t_vr, 1);
    endtask

    initial begin
        wait_cyc(3);
        chk({en_dc, en_5v, en_3v3, en_vr, pwr_ok, fault} == 6'b0, "R1 reset state",
            int'({en_dc, en_5v, en_3v3, en_vr, pwr_ok, fault}), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk({en_dc, en_vr, pwr_ok, fault} == 4'b0, "R1 idle after reset",
            int'({en_dc, en_vr, pwr_ok, fault}), 0);

        // R2: DC enable comes up alone before the planes
        pwr_req = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (en_dc) break;
        end
        chk(en_dc && !en_5v && !en_3v3 && !en_vr, "R2 DC enable first",
            int'({en_dc, en_5v, en_3v3, en_vr}), 8);
        pwr_req = 1'b0;
        wait_cyc(30);

        // R4 / R5 / R10: sweep power-good delay across the timeout boundary
        for (int dly = 0; dly <= TMO + 1; dly++) begin
            bit exp_ok;
            exp_ok = (dly <= TMO - 3);
            pg_delay = dly;
            pwr_req = 1'b1;
            wait_vr_rise();
            wait_cyc(TMO + 8);
            chk(pwr_ok == exp_ok, "R5 power-good window", int'(pwr_ok), int'(exp_ok));
            chk(fault == !exp_ok, "R10 fault latched", int'(fault), int'(!exp_ok));
            chk(en_dc && en_5v && en_3v3, "R10 rails held", int'({en_dc, en_5v, en_3v3}), 7);
            if (!exp_ok) begin
                chk(en_vr == 1'b0, "R4 regulator off after timeout", int'(en_vr), 0);
                chk(last_vr_len == TMO, "R4 enable width", last_vr_len, TMO);
            end
            power_down_and_check("R8 sweep");
        end

        // R6: switched rail loss drops power-ok after three cycles, regulator stays on
        pg_delay = 0;
        pwr_req = 1'b1;
        wait_vr_rise();
        wait_cyc(8);
        chk(pwr_ok == 1'b1, "R6 running", int'(pwr_ok), 1);
        good_sw = 1'b0;
        wait_cyc(2);
        chk(pwr_ok == 1'b1, "R6 sync latency", int'(pwr_ok), 1);
        wait_cyc(1);
        chk(pwr_ok == 1'b0, "R6 follows switched rail low", int'(pwr_ok), 0);
        wait_cyc(5);
        chk(en_vr == 1'b1 && pwr_ok == 1'b0, "R6 regulator stays on in sleep",
            int'({en_vr, pwr_ok}), 2);
        good_sw = 1'b1;
        wait_cyc(3);
        chk(pwr_ok == 1'b1, "R6 returns with switched rail", int'(pwr_ok), 1);
        power_down_and_check("R8 after sleep");

        // R9: each rail flag dropping while running triggers ordered shutdown
        for (int r = 0; r < 3; r++) begin
            pwr_req = 1'b1;
            wait_vr_rise();
            wait_cyc(8);
            chk(pwr_ok == 1'b1, "R9 running before drop", int'(pwr_ok), 1);
            t_vr = 0; t_pl = 0; t_dc = 0;
            drop_dc  = (r == 0);
            drop_5v  = (r == 1);
            drop_3v3 = (r == 2);
            wait_cyc(30);
            chk(en_vr == 1'b0 && pwr_ok == 1'b0, "R9 regulator off on rail loss",
                int'({en_vr, pwr_ok}), 0);
            chk(t_vr > 0 && t_vr < t_pl && t_pl < t_dc, "R9 ordered shutdown on rail loss",
                t_dc - t_vr, 1);
            chk(fault == 1'b0, "R9 no fault on rail loss", int'(fault), 0);
            pwr_req = 1'b0;
            wait_cyc(30);
            drop_dc = 1'b0; drop_5v = 1'b0; drop_3v3 = 1'b0;
            wait_cyc(5);
        end

        done = 1'b1;
        summary();
    end
endmodule